// File: doc/BRIEF.md
# Unified Forward/Inverse NTT Butterfly Unit

This block performs one radix-2 butterfly of the number theoretic transform over the ring with modulus q = 3329, on 12-bit coefficients. A single mode bit, carried with every operand set, picks the form. Mode 0 is the decimation-in-time form used by the forward transform: the twiddle multiplies the second coefficient before the sum and difference are formed. Mode 1 is the decimation-in-frequency form used by the inverse transform: the sum and difference come first, and the difference is then multiplied by the twiddle.

One multiplier and one Barrett reducer serve both forms. Routing multiplexers decide what the multiplier sees and what the final adder and subtractor combine. The datapath has four register stages, takes one operand set per clock and may switch modes on any cycle. A surrounding transform engine supplies coefficients and twiddles and collects the two results. That engine also owns addressing, twiddle storage, loop sequencing and the final scaling of the inverse transform.

Top module: `ntt_unified_butterfly`

## Requirements
- R1: With mode 0 the outputs are out_a = (a + w·b) mod 3329 and out_b = (a − w·b) mod 3329.
- R2: With mode 1 the outputs are out_a = (a + b) mod 3329 and out_b = w·(a − b) mod 3329.
- R3: Whenever out_valid is high, both out_a and out_b lie in the range 0 to 3328.
- R4: out_valid is high exactly when in_valid was high at the clock edge four cycles earlier, and the results shown belong to that input set.
- R5: A new input set is accepted on every clock. The mode is captured with each set, so a stream that mixes modes cycle by cycle gives the correct result for every set.
- R6: Operands at the range limits, 0 and 3328, give correct results in both modes for every combination of a, b and w.
- R7: While rst_n is low, out_valid, out_a and out_b are 0. Sets in flight when reset is asserted never appear. After release, out_valid stays low until an input set accepted after release has passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set present this cycle |
| in_mode | input | 1 | 0 = forward form, 1 = inverse form |
| in_a | input | 12 | First coefficient, 0 to 3328 |
| in_b | input | 12 | Second coefficient, 0 to 3328 |
| in_w | input | 12 | Twiddle factor, 0 to 3328 |
| out_valid | output | 1 | Result present this cycle |
| out_a | output | 12 | First result |
| out_b | output | 12 | Second result |

## Verification
Both results of a set become visible four rising edges after that set is sampled, in either mode. The bench therefore drives a new set and samples the outputs on each falling edge, and compares the outputs seen at falling edge n+4 with what the set driven at falling edge n should produce. It also checks that out_valid is low in every cycle whose matching slot held no set. The same four-cycle offset is used for the table vectors, the limit-value sweep and the mixed-mode random stream. After a reset asserted in mid-stream, the bench watches six further cycles to confirm that nothing emerges.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;

  localparam int unsigned BF_Q   = 3329;
  localparam int unsigned BF_CW  = 12;
  localparam int unsigned BF_PW  = 2 * BF_CW;
  localparam int unsigned BF_SH  = BF_PW;
  localparam int unsigned BF_M   = (1 << BF_SH) / BF_Q;
  localparam int unsigned BF_MW  = $clog2(BF_M + 1);
  localparam int unsigned BF_EW  = BF_PW + BF_MW;
  localparam int unsigned BF_LAT = 4;

  typedef logic [BF_CW-1:0] coef_t;
  typedef logic [BF_PW-1:0] prod_t;

  typedef enum logic {
    BF_FWD_CT = 1'b0,
    BF_INV_GS = 1'b1
  } bf_mode_e;

  function automatic coef_t bf_mod_add(input coef_t x, input coef_t y);
    logic [BF_CW:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= (BF_CW+1)'(BF_Q)) s = s - (BF_CW+1)'(BF_Q);
    return s[BF_CW-1:0];
  endfunction

  function automatic coef_t bf_mod_sub(input coef_t x, input coef_t y);
    logic [BF_CW:0] d;
    d = {1'b0, x} - {1'b0, y};
    if (x < y) d = d + (BF_CW+1)'(BF_Q);
    return d[BF_CW-1:0];
  endfunction

endpackage

// File: rtl/ntt_bf_premul.sv
module ntt_bf_premul
  import ntt_bfly_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  bf_mode_e in_mode,
  input  coef_t    in_a,
  input  coef_t    in_b,
  input  coef_t    in_w,
  output logic     m_valid,
  output bf_mode_e m_mode,
  output coef_t    m_a,
  output coef_t    m_b,
  output prod_t    m_prod
);

  // stage 1: the pre-multiply difference the inverse form needs
  logic     s1_valid;
  bf_mode_e s1_mode;
  coef_t    s1_a, s1_b, s1_w, s1_diff;
  coef_t    diff_now;

  assign diff_now = bf_mod_sub(in_a, in_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= BF_FWD_CT;
      s1_a     <= '0;
      s1_b     <= '0;
      s1_w     <= '0;
      s1_diff  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_mode  <= in_mode;
      s1_a     <= in_a;
      s1_b     <= in_b;
      s1_w     <= in_w;
      s1_diff  <= diff_now;
    end
  end

  // stage 2: operand mux in front of the only multiplier
  coef_t mul_opnd;
  prod_t mul_full;

  assign mul_opnd = (s1_mode == BF_INV_GS) ? s1_diff : s1_b;
  assign mul_full = BF_PW'(s1_w) * BF_PW'(mul_opnd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_mode  <= BF_FWD_CT;
      m_a     <= '0;
      m_b     <= '0;
      m_prod  <= '0;
    end else begin
      m_valid <= s1_valid;
      m_mode  <= s1_mode;
      m_a     <= s1_a;
      m_b     <= s1_b;
      m_prod  <= mul_full;
    end
  end

  // R2: the registered difference is already a reduced residue
  a_r2_diff_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (int'(s1_diff) < int'(BF_Q)));

  // R3: the product stays below q squared, the range Barrett is sized for
  a_r3_prod_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (int'(m_prod) < int'(BF_Q) * int'(BF_Q)));

endmodule

// File: rtl/ntt_bf_barrett.sv
module ntt_bf_barrett
  import ntt_bfly_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  bf_mode_e in_mode,
  input  coef_t    in_a,
  input  coef_t    in_b,
  input  prod_t    in_prod,
  output logic     r_valid,
  output bf_mode_e r_mode,
  output coef_t    r_a,
  output coef_t    r_b,
  output coef_t    r_val
);

  logic [BF_EW-1:0] est_full;
  logic [BF_MW-1:0] quot_est;
  prod_t            rem_raw;
  logic             corr_taken;
  coef_t            rem_fixed;

  assign est_full   = BF_EW'(in_prod) * BF_EW'(BF_M);
  assign quot_est   = est_full[BF_EW-1 -: BF_MW];
  assign rem_raw    = in_prod - BF_PW'(quot_est) * BF_PW'(BF_Q);
  assign corr_taken = (rem_raw >= BF_PW'(BF_Q));
  assign rem_fixed  = corr_taken ? coef_t'(rem_raw - BF_PW'(BF_Q)) : coef_t'(rem_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_mode  <= BF_FWD_CT;
      r_a     <= '0;
      r_b     <= '0;
      r_val   <= '0;
    end else begin
      r_valid <= in_valid;
      r_mode  <= in_mode;
      r_a     <= in_a;
      r_b     <= in_b;
      r_val   <= rem_fixed;
    end
  end

  // R3: a single correction by q suffices for every in-range product
  a_r3_one_correction: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(rem_raw) < 2 * int'(BF_Q)));

  // R1, R2: the reducer output equals the true remainder of the product
  a_r1_reduce_exact: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> (int'(r_val) == int'($past(in_prod)) % int'(BF_Q)));

endmodule

// File: rtl/ntt_bf_postadd.sv
module ntt_bf_postadd
  import ntt_bfly_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  bf_mode_e in_mode,
  input  coef_t    in_a,
  input  coef_t    in_b,
  input  coef_t    in_r,
  output logic     out_valid,
  output coef_t    out_a,
  output coef_t    out_b
);

  // operand muxes for the shared adder and subtractor
  coef_t add_rhs, sub_lhs, sub_rhs;
  coef_t sum_now, dif_now;
  logic  inv_sel;

  assign inv_sel = (in_mode == BF_INV_GS);
  assign add_rhs = inv_sel ? in_b : in_r;
  assign sub_lhs = inv_sel ? in_r : in_a;
  assign sub_rhs = inv_sel ? '0   : in_r;
  assign sum_now = bf_mod_add(in_a, add_rhs);
  assign dif_now = bf_mod_sub(sub_lhs, sub_rhs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
    end else begin
      out_valid <= in_valid;
      out_a     <= sum_now;
      out_b     <= dif_now;
    end
  end

  // R3: both results leave reduced
  a_r3_out_a_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_a) < int'(BF_Q)));
  a_r3_out_b_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_b) < int'(BF_Q)));

endmodule

// File: rtl/ntt_unified_butterfly.sv
module ntt_unified_butterfly
  import ntt_bfly_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_mode,
  input  logic [BF_CW-1:0]    in_a,
  input  logic [BF_CW-1:0]    in_b,
  input  logic [BF_CW-1:0]    in_w,
  output logic                out_valid,
  output logic [BF_CW-1:0]    out_a,
  output logic [BF_CW-1:0]    out_b
);

  logic     m_valid, r_valid;
  bf_mode_e m_mode, r_mode;
  coef_t    m_a, m_b, r_a, r_b, r_val;
  prod_t    m_prod;

  ntt_bf_premul u_premul (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_mode  (bf_mode_e'(in_mode)),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_w     (in_w),
    .m_valid  (m_valid),
    .m_mode   (m_mode),
    .m_a      (m_a),
    .m_b      (m_b),
    .m_prod   (m_prod)
  );

  ntt_bf_barrett u_barrett (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (m_valid),
    .in_mode  (m_mode),
    .in_a     (m_a),
    .in_b     (m_b),
    .in_prod  (m_prod),
    .r_valid  (r_valid),
    .r_mode   (r_mode),
    .r_a      (r_a),
    .r_b      (r_b),
    .r_val    (r_val)
  );

  ntt_bf_postadd u_postadd (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (r_valid),
    .in_mode   (r_mode),
    .in_a      (r_a),
    .in_b      (r_b),
    .in_r      (r_val),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b)
  );

  // cycles since reset release, saturating at the latency, for the checks below
  logic [2:0] since_rst;
  logic       window_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_rst <= '0;
    else if (since_rst != 3'(BF_LAT))     since_rst <= since_rst + 3'd1;
  end

  assign window_full = (since_rst == 3'(BF_LAT));

  // R7: nothing appears before a post-reset input has crossed the pipe
  a_r7_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !window_full |-> !out_valid);

  // R4: output strobe follows the input strobe by four edges
  a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    window_full |-> (out_valid == $past(in_valid, 4)));

  // R1: forward form against a remainder-operator reference
  a_r1_forward_result: assert property (@(posedge clk) disable iff (!rst_n)
    (window_full && out_valid && !$past(in_mode, 4)) |->
      ((int'(out_a) == (int'($past(in_a, 4)) + (int'($past(in_w, 4)) * int'($past(in_b, 4))) % int'(BF_Q)) % int'(BF_Q)) &&
       (int'(out_b) == (int'($past(in_a, 4)) + int'(BF_Q) - (int'($past(in_w, 4)) * int'($past(in_b, 4))) % int'(BF_Q)) % int'(BF_Q))));

  // R2: inverse form against a remainder-operator reference
  a_r2_inverse_result: assert property (@(posedge clk) disable iff (!rst_n)
    (window_full && out_valid && $past(in_mode, 4)) |->
      ((int'(out_a) == (int'($past(in_a, 4)) + int'($past(in_b, 4))) % int'(BF_Q)) &&
       (int'(out_b) == (int'($past(in_w, 4)) * ((int'($past(in_a, 4)) + int'(BF_Q) - int'($past(in_b, 4))) % int'(BF_Q))) % int'(BF_Q))));

endmodule

// File: tb/ntt_unified_butterfly_bench.sv
module ntt_unified_butterfly_bench;

  localparam int QM    = 3329;
  localparam int NTAB  = 8;
  localparam int NCORN = 16;
  localparam int NRAND = 400;
  localparam int NITEM = NTAB + 1 + NCORN + NRAND;

  typedef struct packed {
    logic        mode;
    logic [11:0] a, b, w, e0, e1;
  } vec_t;

  // hand-computed vectors: mode, a, b, w, expected out_a, expected out_b
  localparam vec_t TAB [NTAB] = '{
    '{1'b0, 12'd5,    12'd7,    12'd3,    12'd26,   12'd3313},
    '{1'b1, 12'd5,    12'd7,    12'd3,    12'd12,   12'd3323},
    '{1'b0, 12'd3328, 12'd3328, 12'd3328, 12'd0,    12'd3327},
    '{1'b1, 12'd3328, 12'd3328, 12'd3328, 12'd3327, 12'd0},
    '{1'b0, 12'd0,    12'd1,    12'd1,    12'd1,    12'd3328},
    '{1'b1, 12'd0,    12'd3328, 12'd3328, 12'd3328, 12'd3328},
    '{1'b0, 12'd1000, 12'd2000, 12'd3000, 12'd2142, 12'd3187},
    '{1'b1, 12'd1000, 12'd2000, 12'd3000, 12'd3000, 12'd2758}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode = 1'b0;
  logic [11:0] in_a = '0, in_b = '0, in_w = '0;
  logic        out_valid;
  logic [11:0] out_a, out_b;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int st_v [NITEM];
  int st_m [NITEM];
  int st_a [NITEM];
  int st_b [NITEM];
  int st_w [NITEM];
  int st_e0 [NITEM];
  int st_e1 [NITEM];
  string st_tag [NITEM];

  always #4 clk = ~clk;

  ntt_unified_butterfly u_ntt_unified_butterfly (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_w      (in_w),
    .out_valid (out_valid),
    .out_a     (out_a),
    .out_b     (out_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model: forward = twiddle times b first, inverse = difference first
  task automatic model(input int m, input int a, input int b, input int w,
                       output int e0, output int e1);
    int t, d;
    if (m == 0) begin
      t  = (w * b) % QM;
      e0 = (a + t) % QM;
      e1 = (a - t + QM) % QM;
    end else begin
      d  = (a - b + QM) % QM;
      e0 = (a + b) % QM;
      e1 = (d * w) % QM;
    end
  endtask

  task automatic drive_idle();
    in_valid = 1'b0;
    in_mode  = 1'b0;
    in_a     = '0;
    in_b     = '0;
    in_w     = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int idx;
    int e0, e1;
    idx = 0;
    // table vectors
    for (int i = 0; i < NTAB; i++) begin
      st_v[idx] = 1; st_m[idx] = int'(TAB[i].mode);
      st_a[idx] = int'(TAB[i].a); st_b[idx] = int'(TAB[i].b); st_w[idx] = int'(TAB[i].w);
      st_e0[idx] = int'(TAB[i].e0); st_e1[idx] = int'(TAB[i].e1);
      st_tag[idx] = TAB[i].mode ? "R2" : "R1";
      idx++;
    end
    // one bubble
    st_v[idx] = 0; st_m[idx] = 0; st_a[idx] = 0; st_b[idx] = 0; st_w[idx] = 0;
    st_e0[idx] = 0; st_e1[idx] = 0; st_tag[idx] = "R4";
    idx++;
    // R6: every combination of limit values in both modes
    for (int k = 0; k < NCORN; k++) begin
      st_v[idx] = 1; st_m[idx] = k & 1;
      st_a[idx] = ((k >> 1) & 1) ? QM - 1 : 0;
      st_b[idx] = ((k >> 2) & 1) ? QM - 1 : 0;
      st_w[idx] = ((k >> 3) & 1) ? QM - 1 : 0;
      model(st_m[idx], st_a[idx], st_b[idx], st_w[idx], e0, e1);
      st_e0[idx] = e0; st_e1[idx] = e1; st_tag[idx] = "R6";
      idx++;
    end
    // R5: random mixed-mode stream with occasional gaps
    for (int k = 0; k < NRAND; k++) begin
      st_v[idx] = (($urandom % 8) != 0) ? 1 : 0;
      st_m[idx] = int'($urandom % 2);
      st_a[idx] = int'($urandom % QM);
      st_b[idx] = int'($urandom % QM);
      st_w[idx] = int'($urandom % QM);
      model(st_m[idx], st_a[idx], st_b[idx], st_w[idx], e0, e1);
      st_e0[idx] = e0; st_e1[idx] = e1; st_tag[idx] = "R5";
      idx++;
    end

    // R7: reset state
    drive_idle();
    repeat (3) @(negedge clk);
    chk("R7 reset out_valid", int'(out_valid), 0);
    chk("R7 reset out_a", int'(out_a), 0);
    chk("R7 reset out_b", int'(out_b), 0);
    rst_n = 1'b1;

    // main stream: item driven at falling edge c is due at falling edge c+4
    for (int c = 0; c < NITEM + 4; c++) begin
      if (c >= 4) begin
        int p;
        p = c - 4;
        chk("R4 out_valid timing", int'(out_valid), st_v[p]);
        if (st_v[p] != 0 && out_valid) begin
          chk({st_tag[p], " out_a"}, int'(out_a), st_e0[p]);
          chk({st_tag[p], " out_b"}, int'(out_b), st_e1[p]);
          chk("R3 out_a range", (int'(out_a) < QM) ? 1 : 0, 1);
          chk("R3 out_b range", (int'(out_b) < QM) ? 1 : 0, 1);
        end
      end else begin
        chk("R7 quiet after release", int'(out_valid), 0);
      end
      if (c < NITEM) begin
        in_valid = st_v[c][0];
        in_mode  = st_m[c][0];
        in_a     = 12'(st_a[c]);
        in_b     = 12'(st_b[c]);
        in_w     = 12'(st_w[c]);
      end else begin
        drive_idle();
      end
      @(negedge clk);
    end

    // R7: reset in mid-stream drops the sets in flight
    in_valid = 1'b1; in_mode = 1'b0; in_a = 12'd9; in_b = 12'd4; in_w = 12'd2;
    @(negedge clk);
    in_mode = 1'b1;
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    #1;
    chk("R7 flush out_valid", int'(out_valid), 0);
    chk("R7 flush out_a", int'(out_a), 0);
    chk("R7 flush out_b", int'(out_b), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R7 no ghost output", int'(out_valid), 0);
    end

    summary();
  end

endmodule